// File: doc/BRIEF.md
# DSI Low-Power Read Turnaround Controller

This block sequences the low-power read handshake of a display serial interface host. When the packet engine reports that a read request, or a DCS write carrying the tear-effect-enable command, has gone out on the link, the controller waits for a programmable number of escape-clock periods. It then raises a turnaround request toward the PHY. While that request is up it times how long the lane takes to reverse direction. Once the lane has turned, it times the incoming low-power data burst. Either wait that runs past its limit leaves a sticky error flag. A separate countdown in system clock cycles reports when the PLL output may be considered stable.

All logic runs on the system clock. The escape-clock time base arrives as a one-cycle enable pulse, `esc_tick`, that is generated elsewhere. Software-visible flags are modelled as sticky bits that are cleared by a one-cycle write-one-to-clear vector. A single `irq` line is the OR of the three sticky bits.

Top module: `dsi_turnaround_ctrl`

## Requirements
- R1: A sent packet starts the turnaround sequence when its 6-bit data type is a read request (0x04, 0x14, 0x24 or 0x06). It also starts the sequence when the data type is a DCS write (0x05, 0x15 or 0x39) whose command byte `pkt_cmd` is 0x35.
- R2: Any other sent packet leaves the controller as it was. This includes DCS writes with a different command and generic writes with command byte 0x35.
- R3: After a start, `bta_req` stays low while `hold_cnt` escape ticks are counted. It rises on the clock edge that follows the edge at which the last of those ticks was counted, or the edge after the start when `hold_cnt` is 0.
- R4: If the lane direction does not change, `bta_req` stays high while `bta_limit` escape ticks are counted. On the next edge `bta_req` drops and `sts_bta_timeout` is set.
- R5: When `phy_dir_rx` is high while `bta_req` is high, `bta_req` drops on the next edge and the turnaround timer stops, so no turnaround timeout follows.
- R6: After the direction change, the first cycle with `rx_lpdt` high arms the receive timer. The timer then counts escape ticks while `rx_valid` stays high. `rx_valid` going low ends the wait with no error. Once `rx_limit` ticks have been counted with `rx_valid` still high, the next edge sets `sts_rx_timeout`.
- R7: A new start in any phase restarts the hold interval with all counters at zero. A pending `bta_req` drops on the next edge.
- R8: Each `sts_clr` bit clears one sticky flag on the next edge. Bit 0 clears the turnaround timeout, bit 1 the receive timeout and bit 2 `irq_clk_stable`. A set in the same cycle wins over the clear.
- R9: `irq` is high exactly when at least one of the three sticky flags is high.
- R10: A `pll_load` pulse loads `pll_time` = N and clears `clk_stable`. `clk_stable` and `irq_clk_stable` become high N+1 edges after the load edge. `clk_stable` then stays high until the next load.
- R11: While reset is held and after its release, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esc_tick | input | 1 | One-cycle pulse per escape-clock period |
| pkt_sent | input | 1 | Packet transmitted strobe |
| pkt_dtype | input | 6 | Data type of the transmitted packet |
| pkt_cmd | input | 8 | First payload byte (DCS command) of the packet |
| hold_cnt | input | 16 | Escape ticks between send and turnaround request |
| bta_limit | input | 8 | Escape ticks allowed for the direction change |
| rx_limit | input | 16 | Escape ticks allowed for the receive burst |
| pll_time | input | 32 | System cycles of the PLL stability countdown |
| pll_load | input | 1 | Loads and starts the PLL countdown |
| phy_dir_rx | input | 1 | Lane direction is receive |
| rx_lpdt | input | 1 | PHY is in low-power receive data mode |
| rx_valid | input | 1 | PHY receive data valid |
| sts_clr | input | 3 | Write-one-to-clear pulses for the sticky flags |
| bta_req | output | 1 | Turnaround request to the PHY |
| sts_bta_timeout | output | 1 | Sticky turnaround timeout flag |
| sts_rx_timeout | output | 1 | Sticky receive timeout flag |
| clk_stable | output | 1 | PLL countdown complete |
| irq_clk_stable | output | 1 | Sticky clock-stable interrupt flag |
| irq | output | 1 | OR of the sticky flags |

## Verification
The assertions check several rules on every cycle. A turnaround request can only rise out of the hold phase. A start always returns the sequencer to a zero hold count. A direction change during a request moves the sequencer into the receive phase. Timeout and clock-stable events always land in their sticky flags. The exact tick counts are shown only by the bench scenarios: it sweeps every hold and turnaround limit from 0 to 3, several receive limits and PLL loads. The same applies to the packet classification and the rearm that discards partial counts. The scenarios also show that a completed receive burst, or a stopped turnaround timer, produces no flag however long the ticks continue.

// File: rtl/dsi_turnaround_pkg.sv
package dsi_turnaround_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_BTA  = 2'd2,
        PH_RX   = 2'd3
    } phase_e;

    localparam logic [5:0] DT_GEN_RD0  = 6'h04;
    localparam logic [5:0] DT_GEN_RD1  = 6'h14;
    localparam logic [5:0] DT_GEN_RD2  = 6'h24;
    localparam logic [5:0] DT_DCS_RD   = 6'h06;
    localparam logic [5:0] DT_DCS_WR0  = 6'h05;
    localparam logic [5:0] DT_DCS_WR1  = 6'h15;
    localparam logic [5:0] DT_DCS_LWR  = 6'h39;
    localparam logic [7:0] CMD_TEAR_ON = 8'h35;

endpackage

// File: rtl/dsi_turnaround_classify.sv
module dsi_turnaround_classify
    import dsi_turnaround_pkg::*;
(
    input  logic       pkt_sent,
    input  logic [5:0] pkt_dtype,
    input  logic [7:0] pkt_cmd,
    output logic       start
);

    logic is_read;
    logic is_dcs_write;

    always_comb begin
        is_read      = (pkt_dtype == DT_GEN_RD0) || (pkt_dtype == DT_GEN_RD1) ||
                       (pkt_dtype == DT_GEN_RD2) || (pkt_dtype == DT_DCS_RD);
        is_dcs_write = (pkt_dtype == DT_DCS_WR0) || (pkt_dtype == DT_DCS_WR1) ||
                       (pkt_dtype == DT_DCS_LWR);
        start        = pkt_sent && (is_read || (is_dcs_write && (pkt_cmd == CMD_TEAR_ON)));
    end

endmodule

// File: rtl/dsi_turnaround_seq.sv
module dsi_turnaround_seq
    import dsi_turnaround_pkg::*;
#(
    parameter int HOLD_W = 16,
    parameter int BTA_W  = 8,
    parameter int RX_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esc_tick,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold_lim,
    input  logic [BTA_W-1:0]  bta_lim,
    input  logic [RX_W-1:0]   rx_lim,
    input  logic              phy_dir_rx,
    input  logic              rx_lpdt,
    input  logic              rx_valid,
    output logic              bta_req,
    output logic              bta_to_set,
    output logic              rx_to_set
);

    typedef struct packed {
        phase_e            ph;
        logic [HOLD_W-1:0] hold;
        logic [BTA_W-1:0]  bta;
        logic [RX_W-1:0]   rx;
        logic              rx_arm;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        bta_to_set = 1'b0;
        rx_to_set  = 1'b0;
        case (seq_q.ph)
            PH_HOLD: begin
                if (seq_q.hold == hold_lim) begin
                    seq_d.ph  = PH_BTA;
                    seq_d.bta = '0;
                end else if (esc_tick) begin
                    seq_d.hold = seq_q.hold + 1'b1;
                end
            end
            PH_BTA: begin
                if (phy_dir_rx) begin
                    seq_d.ph     = PH_RX;
                    seq_d.rx     = '0;
                    seq_d.rx_arm = 1'b0;
                end else if (seq_q.bta == bta_lim) begin
                    seq_d.ph   = PH_IDLE;
                    bta_to_set = 1'b1;
                end else if (esc_tick) begin
                    seq_d.bta = seq_q.bta + 1'b1;
                end
            end
            PH_RX: begin
                if (!seq_q.rx_arm) begin
                    if (rx_lpdt) begin
                        seq_d.rx_arm = 1'b1;
                        seq_d.rx     = '0;
                    end
                end else if (!rx_valid) begin
                    seq_d.ph = PH_IDLE;
                end else if (seq_q.rx == rx_lim) begin
                    seq_d.ph  = PH_IDLE;
                    rx_to_set = 1'b1;
                end else if (esc_tick) begin
                    seq_d.rx = seq_q.rx + 1'b1;
                end
            end
            default: ;
        endcase
        if (start) begin
            seq_d.ph     = PH_HOLD;
            seq_d.hold   = '0;
            seq_d.bta    = '0;
            seq_d.rx     = '0;
            seq_d.rx_arm = 1'b0;
            bta_to_set   = 1'b0;
            rx_to_set    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, hold: '0, bta: '0, rx: '0, rx_arm: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bta_req = (seq_q.ph == PH_BTA);

    AST_REQ_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bta_req) |-> $past(seq_q.ph == PH_HOLD)); // R3
    AST_DIR_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_BTA && phy_dir_rx && !start) |=> (seq_q.ph == PH_RX && !bta_req)); // R5
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (seq_q.ph == PH_HOLD && seq_q.hold == '0 && !bta_req)); // R7

endmodule

// File: rtl/dsi_turnaround_pll.sv
module dsi_turnaround_pll #(
    parameter int PLL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pll_load,
    input  logic [PLL_W-1:0] pll_time,
    output logic             stable,
    output logic             stable_set
);

    typedef struct packed {
        logic [PLL_W-1:0] cnt;
        logic             run;
        logic             stable;
    } pll_t;

    pll_t pll_d, pll_q;

    always_comb begin
        pll_d      = pll_q;
        stable_set = 1'b0;
        if (pll_load) begin
            pll_d.cnt    = pll_time;
            pll_d.run    = 1'b1;
            pll_d.stable = 1'b0;
        end else if (pll_q.run) begin
            if (pll_q.cnt == '0) begin
                pll_d.run    = 1'b0;
                pll_d.stable = 1'b1;
                stable_set   = 1'b1;
            end else begin
                pll_d.cnt = pll_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_q <= '{cnt: '0, run: 1'b0, stable: 1'b0};
        end else begin
            pll_q <= pll_d;
        end
    end

    assign stable = pll_q.stable;

    AST_LOAD_CLEARS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_load |=> !stable); // R10
    AST_RUNNING_NOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_q.run |-> !stable); // R10

endmodule

// File: rtl/dsi_turnaround_ctrl.sv
module dsi_turnaround_ctrl
    import dsi_turnaround_pkg::*;
#(
    parameter int HOLD_W = 16,
    parameter int BTA_W  = 8,
    parameter int RX_W   = 16,
    parameter int PLL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esc_tick,
    input  logic              pkt_sent,
    input  logic [5:0]        pkt_dtype,
    input  logic [7:0]        pkt_cmd,
    input  logic [HOLD_W-1:0] hold_cnt,
    input  logic [BTA_W-1:0]  bta_limit,
    input  logic [RX_W-1:0]   rx_limit,
    input  logic [PLL_W-1:0]  pll_time,
    input  logic              pll_load,
    input  logic              phy_dir_rx,
    input  logic              rx_lpdt,
    input  logic              rx_valid,
    input  logic [2:0]        sts_clr,
    output logic              bta_req,
    output logic              sts_bta_timeout,
    output logic              sts_rx_timeout,
    output logic              clk_stable,
    output logic              irq_clk_stable,
    output logic              irq
);

    localparam int NFLAG = 3;

    logic             start_w;
    logic             bta_to_w;
    logic             rx_to_w;
    logic             pll_set_w;
    logic [NFLAG-1:0] flag_d, flag_q;

    dsi_turnaround_classify u_classify (
        .pkt_sent  (pkt_sent),
        .pkt_dtype (pkt_dtype),
        .pkt_cmd   (pkt_cmd),
        .start     (start_w)
    );

    dsi_turnaround_seq #(
        .HOLD_W (HOLD_W),
        .BTA_W  (BTA_W),
        .RX_W   (RX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .esc_tick   (esc_tick),
        .start      (start_w),
        .hold_lim   (hold_cnt),
        .bta_lim    (bta_limit),
        .rx_lim     (rx_limit),
        .phy_dir_rx (phy_dir_rx),
        .rx_lpdt    (rx_lpdt),
        .rx_valid   (rx_valid),
        .bta_req    (bta_req),
        .bta_to_set (bta_to_w),
        .rx_to_set  (rx_to_w)
    );

    dsi_turnaround_pll #(
        .PLL_W (PLL_W)
    ) u_pll (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_load   (pll_load),
        .pll_time   (pll_time),
        .stable     (clk_stable),
        .stable_set (pll_set_w)
    );

    always_comb begin
        flag_d = (flag_q & ~sts_clr) | {pll_set_w, rx_to_w, bta_to_w};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign sts_bta_timeout = flag_q[0];
    assign sts_rx_timeout  = flag_q[1];
    assign irq_clk_stable  = flag_q[2];
    assign irq             = |flag_q;

    AST_READ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_sent && pkt_dtype == DT_DCS_RD) |-> start_w); // R1
    AST_GENERIC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_sent && pkt_dtype == 6'h29) |-> !start_w); // R2
    AST_BTA_TIMEOUT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        bta_to_w |=> (sts_bta_timeout && !bta_req)); // R4
    AST_RX_TIMEOUT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_to_w |=> sts_rx_timeout); // R6
    AST_STABLE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stable) |-> (irq_clk_stable && irq)); // R10

endmodule

// File: tb/dsi_turnaround_ctrl_test.sv
module dsi_turnaround_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        esc_tick = 1'b0;
    logic        pkt_sent = 1'b0;
    logic [5:0]  pkt_dtype = '0;
    logic [7:0]  pkt_cmd = '0;
    logic [15:0] hold_cnt = '0;
    logic [7:0]  bta_limit = '0;
    logic [15:0] rx_limit = '0;
    logic [31:0] pll_time = '0;
    logic        pll_load = 1'b0;
    logic        phy_dir_rx = 1'b0;
    logic        rx_lpdt = 1'b0;
    logic        rx_valid = 1'b0;
    logic [2:0]  sts_clr = '0;
    logic        bta_req, sts_bta_timeout, sts_rx_timeout;
    logic        clk_stable, irq_clk_stable, irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsi_turnaround_ctrl uut (
        .clk(clk), .rst_n(rst_n), .esc_tick(esc_tick), .pkt_sent(pkt_sent),
        .pkt_dtype(pkt_dtype), .pkt_cmd(pkt_cmd), .hold_cnt(hold_cnt),
        .bta_limit(bta_limit), .rx_limit(rx_limit), .pll_time(pll_time),
        .pll_load(pll_load), .phy_dir_rx(phy_dir_rx), .rx_lpdt(rx_lpdt),
        .rx_valid(rx_valid), .sts_clr(sts_clr), .bta_req(bta_req),
        .sts_bta_timeout(sts_bta_timeout), .sts_rx_timeout(sts_rx_timeout),
        .clk_stable(clk_stable), .irq_clk_stable(irq_clk_stable), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic send(input logic [5:0] dt, input logic [7:0] cmd);
        pkt_sent = 1'b1; pkt_dtype = dt; pkt_cmd = cmd;
        cyc();
        pkt_sent = 1'b0;
    endtask

    task automatic tick();
        esc_tick = 1'b1;
        cyc();
        esc_tick = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        sts_clr = m;
        cyc();
        sts_clr = '0;
    endtask

    // start with a DCS read, count the hold, land in the request phase
    task automatic to_bta(input int h);
        send(6'h06, 8'h00);
        repeat (h) tick();
        cyc();
        chk("R3 request after hold", 32'(bta_req), 1);
    endtask

    function automatic logic [13:0] start_kind(input int k);
        case (k)
            0: return {6'h04, 8'h00};
            1: return {6'h14, 8'h11};
            2: return {6'h24, 8'h22};
            3: return {6'h06, 8'h0A};
            4: return {6'h05, 8'h35};
            5: return {6'h15, 8'h35};
            default: return {6'h39, 8'h35};
        endcase
    endfunction

    function automatic logic [13:0] other_kind(input int k);
        case (k)
            0: return {6'h15, 8'h29};
            1: return {6'h29, 8'h35};
            2: return {6'h03, 8'h35};
            3: return {6'h05, 8'h11};
            4: return {6'h39, 8'h2C};
            default: return {6'h37, 8'h35};
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        chk("R11 reset bta_req", 32'(bta_req), 0);
        chk("R11 reset irq", 32'(irq), 0);
        rst_n = 1'b1;
        cyc();
        chk("R11 after reset outputs", {26'd0, bta_req, sts_bta_timeout, sts_rx_timeout,
            clk_stable, irq_clk_stable, irq}, 0);

        // hold and turnaround-limit sweep, all start kinds
        for (int h = 0; h < 4; h++) begin
            for (int b = 0; b < 4; b++) begin
                logic [13:0] kd;
                kd = start_kind((h * 4 + b) % 7);
                hold_cnt = 16'(h); bta_limit = 8'(b);
                send(kd[13:8], kd[7:0]);
                for (int i = 0; i < h; i++) begin
                    chk("R3 no request during hold", 32'(bta_req), 0);
                    tick();
                end
                chk("R1 start then hold low", 32'(bta_req), 0);
                cyc();
                chk("R1 start kind raises request", 32'(bta_req), 1);
                repeat (b) tick();
                chk("R4 request held before limit", 32'(bta_req), 1);
                chk("R4 no timeout before limit", 32'(sts_bta_timeout), 0);
                cyc();
                chk("R4 timeout flag", 32'(sts_bta_timeout), 1);
                chk("R4 request dropped", 32'(bta_req), 0);
                chk("R9 irq from timeout", 32'(irq), 1);
                clear(3'b001);
                chk("R8 timeout cleared", 32'(sts_bta_timeout), 0);
                chk("R9 irq low", 32'(irq), 0);
            end
        end

        // packets that must not start anything
        hold_cnt = 16'd0; bta_limit = 8'd2;
        for (int k = 0; k < 6; k++) begin
            logic [13:0] kd;
            kd = other_kind(k);
            send(kd[13:8], kd[7:0]);
            repeat (4) tick();
            chk("R2 ignored packet no request", 32'(bta_req), 0);
            chk("R2 ignored packet no timeout", 32'(sts_bta_timeout), 0);
        end

        // direction change, then receive timeout sweep
        hold_cnt = 16'd1; bta_limit = 8'd3;
        for (int l = 0; l < 4; l++) begin
            rx_limit = 16'(l);
            to_bta(1);
            tick();
            phy_dir_rx = 1'b1;
            cyc();
            chk("R5 request drops on direction", 32'(bta_req), 0);
            repeat (6) tick();
            chk("R5 no turnaround timeout", 32'(sts_bta_timeout), 0);
            rx_lpdt = 1'b1; rx_valid = 1'b1;
            cyc();
            repeat (l) tick();
            chk("R6 no receive timeout before limit", 32'(sts_rx_timeout), 0);
            cyc();
            chk("R6 receive timeout flag", 32'(sts_rx_timeout), 1);
            rx_lpdt = 1'b0; rx_valid = 1'b0; phy_dir_rx = 1'b0;
            clear(3'b010);
            chk("R8 receive timeout cleared", 32'(sts_rx_timeout), 0);
        end

        // receive burst that ends in time
        rx_limit = 16'd2;
        to_bta(1);
        phy_dir_rx = 1'b1;
        cyc();
        rx_lpdt = 1'b1; rx_valid = 1'b1;
        cyc();
        tick();
        rx_valid = 1'b0;
        cyc();
        rx_valid = 1'b1;
        repeat (5) tick();
        chk("R6 completed burst no timeout", 32'(sts_rx_timeout), 0);
        rx_lpdt = 1'b0; rx_valid = 1'b0; phy_dir_rx = 1'b0;

        // rearm during a pending request
        hold_cnt = 16'd2; bta_limit = 8'd3;
        to_bta(2);
        tick(); tick();
        send(6'h14, 8'h00);
        chk("R7 restart drops request", 32'(bta_req), 0);
        tick(); tick();
        cyc();
        chk("R7 request after full hold", 32'(bta_req), 1);
        tick(); tick(); tick();
        chk("R7 turnaround count restarted", 32'(sts_bta_timeout), 0);
        cyc();
        chk("R7 timeout after full count", 32'(sts_bta_timeout), 1);
        clear(3'b001);

        // PLL countdown
        for (int p = 0; p < 4; p++) begin
            int n;
            n = (p == 3) ? 17 : p * p + p;
            pll_time = 32'(n);
            pll_load = 1'b1;
            cyc();
            pll_load = 1'b0;
            chk("R10 load clears stable", 32'(clk_stable), 0);
            repeat (n) cyc();
            chk("R10 not yet stable", 32'(clk_stable), 0);
            cyc();
            chk("R10 stable after count", 32'(clk_stable), 1);
            chk("R10 stable interrupt", 32'(irq_clk_stable), 1);
            chk("R9 irq from pll", 32'(irq), 1);
            clear(3'b100);
            chk("R8 pll interrupt cleared", 32'(irq_clk_stable), 0);
            chk("R10 stable level kept", 32'(clk_stable), 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule